// File: doc/BRIEF.md
# Microstepping Stepper Motor Bridge Driver

This block turns step and direction commands into gate signals for two H-bridges, one per winding of a bipolar permanent-magnet stepper motor. An electrical angle register splits one electrical cycle into 32 positions. Each rising edge on the step input moves the angle forward or backward. The size of that move is chosen at run time from four resolutions: full step, half, quarter and eighth.

The angle addresses two computed lookup tables of unsigned current magnitudes. One table follows a cosine of the angle and one follows a sine, so the two winding references stay a quarter of an electrical cycle apart. The sign of each reference comes from the quadrant of the angle. It picks which diagonal pair of the bridge conducts.

One shared 8-bit counter runs freely and produces a pulse-width-modulated gate for each bridge. Duty and polarity are taken only when the counter wraps. When a bridge's polarity flips, that bridge stays off for a programmable guard interval at the start of the new period. An enable input removes all drive without losing the angle.

Top module: `stepper_microstep_drv`

## Requirements
- R1: After the synchronous active-low reset releases, the angle reads 0 and all four gates stay low for the first 256 clock cycles (the first counter period). In the second period winding A forward is high for 255 cycles and the other gates stay low.
- R2: The angle changes only on the cycle that follows a low-to-high transition of `step`. It moves by 8, 4, 2 or 1 for `mode` values 0, 1, 2 and 3 (full, half, quarter, eighth). It counts up when `dir` is 1 and down when `dir` is 0, modulo 32. Holding `step` high moves it only once.
- R3: For angle i, the magnitude of winding A is round(255·|cos(2πi/32)|) and the magnitude of winding B is round(255·|sin(2πi/32)|).
- R4: Winding A drives its forward gate when i is in 0..7 or 24..31, and its reverse gate otherwise. Winding B drives forward when i is in 0..15 and reverse otherwise.
- R5: The counter starts at 0 after reset and has a period of 256 cycles. Within a period, the active gate of a winding is high while the count is below that winding's latched magnitude, so it is high for exactly that many cycles. It is low at count 255.
- R6: A new magnitude and polarity take effect only at the start of a counter period. A step whose angle update falls on the wrap cycle does not change the period that begins there.
- R7: When a winding's latched polarity differs from the previous period, both of its gates stay low for `guard_len` cycles from the start of that period. The active gate then goes high at count `guard_len`.
- R8: While `enable` is low, all four gates are low. The angle keeps its value and resumes driving the same currents once `enable` returns high.
- R9: The forward and reverse gates of the same bridge are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | High to allow bridge drive |
| step | input | 1 | Step command; its rising edge moves the angle |
| dir | input | 1 | 1 counts the angle up, 0 counts it down |
| mode | input | 2 | Step resolution: 0 full, 1 half, 2 quarter, 3 eighth |
| guard_len | input | 8 | Off interval in clock cycles after a polarity flip |
| elec_angle | output | 5 | Current electrical angle position |
| a_fwd | output | 1 | Winding A bridge, forward diagonal gate |
| a_rev | output | 1 | Winding A bridge, reverse diagonal gate |
| b_fwd | output | 1 | Winding B bridge, forward diagonal gate |
| b_rev | output | 1 | Winding B bridge, reverse diagonal gate |

## Verification
An angle update and the duty latch can land on the same clock edge, when a step edge arrives on the cycle where the PWM counter wraps. The bench provokes this on purpose: it raises `step` so that it is sampled exactly on the wrap edge. It then measures the period that begins there, which must still show the old magnitudes, and the period after, which must show the new ones. A polarity flip and a step of the angle in the same period are also combined with a non-zero guard. The bench then judges the position of the first high gate cycle and the absence of overlap between the two gates of a bridge.

// File: rtl/stp_pkg.sv
// Shared definitions for the microstepping bridge driver.
// Assumes a 32-position electrical cycle and 8-bit magnitudes; the quarter
// wave below is computed for exactly that resolution.
package stp_pkg;

    localparam int ANG_W = 5;   // electrical angle bits (32 positions)
    localparam int TBL_W = 8;   // magnitude and PWM counter bits

    // Step resolution selected by the mode input.
    typedef enum logic [1:0] {
        MS_FULL    = 2'd0,
        MS_HALF    = 2'd1,
        MS_QUARTER = 2'd2,
        MS_EIGHTH  = 2'd3
    } ustep_e;

    // Quarter-wave sine, 255 * sin(k * pi / 16), k = 0..8, rounded.
    function automatic logic [TBL_W-1:0] qtr_sine(input logic [ANG_W-2:0] k);
        logic [TBL_W-1:0] v;
        case (k)
            4'd0:    v = 8'd0;
            4'd1:    v = 8'd50;
            4'd2:    v = 8'd98;
            4'd3:    v = 8'd142;
            4'd4:    v = 8'd180;
            4'd5:    v = 8'd212;
            4'd6:    v = 8'd236;
            4'd7:    v = 8'd250;
            default: v = 8'd255;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stp_angle_counter.sv
// Electrical angle register.
// Moves by a resolution-dependent stride on each rising edge of the step
// input, up or down, wrapping modulo 2**IDX_W. Assumes step is synchronous
// to clk.
module stp_angle_counter #(
    parameter int IDX_W = stp_pkg::ANG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             dir,
    input  logic [1:0]       mode,
    output logic [IDX_W-1:0] idx
);
    import stp_pkg::*;

    // A full step is a quarter of the electrical cycle.
    localparam logic [IDX_W-1:0] FULL_INC = IDX_W'(1 << (IDX_W - 2));

    logic             step_q;
    logic             step_rise;
    logic [IDX_W-1:0] stride;

    // Remember the previous step level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= 1'b0;
        else        step_q <= step;
    end

    // Decode the stride from the selected resolution.
    always_comb begin
        step_rise = step & ~step_q;
        case (ustep_e'(mode))
            MS_FULL:    stride = FULL_INC;
            MS_HALF:    stride = FULL_INC >> 1;
            MS_QUARTER: stride = FULL_INC >> 2;
            default:    stride = FULL_INC >> 3;
        endcase
    end

    // Advance or retreat the angle on a step edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx <= '0;
        else if (step_rise) idx <= dir ? (idx + stride) : (idx - stride);
    end

endmodule

// File: rtl/stp_wave_rom.sv
// Computed magnitude table for one winding.
// Folds the angle into one quarter wave and looks up an unsigned magnitude;
// the sign comes from the half cycle. PHASE_OFS shifts the angle, so a
// quarter-cycle offset turns the sine table into a cosine table.
// Assumes IDX_W matches the quarter-wave resolution in stp_pkg.
module stp_wave_rom #(
    parameter int IDX_W     = stp_pkg::ANG_W,
    parameter int MAG_W     = stp_pkg::TBL_W,
    parameter int PHASE_OFS = 0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag,
    output logic             neg
);
    import stp_pkg::*;

    localparam int               SUB_W = IDX_W - 2;
    localparam logic [SUB_W:0]   QSPAN = (SUB_W+1)'(1 << SUB_W);
    localparam logic [IDX_W-1:0] OFS   = IDX_W'(PHASE_OFS);

    logic [IDX_W-1:0] shifted;
    logic [1:0]       quad;
    logic [SUB_W:0]   sub;
    logic [SUB_W:0]   fold;

    // Fold the shifted angle into the first quadrant and look it up.
    always_comb begin
        shifted = idx + OFS;
        quad    = shifted[IDX_W-1 -: 2];
        sub     = {1'b0, shifted[SUB_W-1:0]};
        fold    = quad[0] ? (QSPAN - sub) : sub;
        mag     = MAG_W'(qtr_sine(fold));
        neg     = quad[1];
    end

endmodule

// File: rtl/stp_bridge_pwm.sv
// PWM and gate logic for one H-bridge.
// Latches magnitude and polarity at the shared counter wrap, blanks both
// diagonals for guard_len cycles after a polarity flip, and drives the
// diagonal that matches the latched polarity while the count is below the
// latched magnitude. Assumes wrap is high exactly when the count is at its
// maximum.
module stp_bridge_pwm #(
    parameter int CNT_W   = stp_pkg::TBL_W,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   pwm_cnt,
    input  logic               wrap,
    input  logic               active,
    input  logic [CNT_W-1:0]   mag,
    input  logic               mag_neg,
    input  logic [GUARD_W-1:0] guard_len,
    output logic               drv_fwd,
    output logic               drv_rev
);
    logic [CNT_W-1:0]   duty_q;
    logic               neg_q;
    logic [GUARD_W-1:0] guard_q;
    logic               conduct;

    // Take the new duty and polarity only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            neg_q  <= 1'b0;
        end else if (wrap) begin
            duty_q <= mag;
            neg_q  <= mag_neg;
        end
    end

    // Load the off interval on a polarity flip, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                        guard_q <= '0;
        else if (wrap && mag_neg != neg_q) guard_q <= guard_len;
        else if (guard_q != '0)            guard_q <= guard_q - 1'b1;
    end

    // Form the two diagonal gates; only one can match the polarity.
    always_comb begin
        conduct = active && (guard_q == '0) && (pwm_cnt < duty_q);
        drv_fwd = conduct & ~neg_q;
        drv_rev = conduct &  neg_q;
    end

endmodule

// File: rtl/stepper_microstep_drv.sv
// Top of the microstepping bridge driver.
// Holds the electrical angle, the shared PWM counter and one table plus
// bridge stage per winding. Winding A follows the cosine of the angle and is
// at full current at angle 0; winding B follows the sine. Drive starts at
// the first counter wrap after reset.
module stepper_microstep_drv #(
    parameter int IDX_W   = stp_pkg::ANG_W,
    parameter int PWM_W   = stp_pkg::TBL_W,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               step,
    input  logic               dir,
    input  logic [1:0]         mode,
    input  logic [GUARD_W-1:0] guard_len,
    output logic [IDX_W-1:0]   elec_angle,
    output logic               a_fwd,
    output logic               a_rev,
    output logic               b_fwd,
    output logic               b_rev
);
    localparam int N_WIND = 2;
    localparam int QTR    = 1 << (IDX_W - 2);

    logic [PWM_W-1:0] pwm_cnt;
    logic             wrap;
    logic             started_q;
    logic             active;
    logic [PWM_W-1:0] mag  [N_WIND];
    logic             neg  [N_WIND];
    logic             fwd  [N_WIND];
    logic             rev  [N_WIND];

    // Angle register driven by the step and direction inputs.
    stp_angle_counter #(.IDX_W(IDX_W)) u_angle (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .dir   (dir),
        .mode  (mode),
        .idx   (elec_angle)
    );

    // Free-running counter shared by both bridges.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_cnt <= '0;
        else        pwm_cnt <= pwm_cnt + 1'b1;
    end

    // Mark that the first period has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)    started_q <= 1'b0;
        else if (wrap) started_q <= 1'b1;
    end

    // Wrap detect and global drive permission.
    always_comb begin
        wrap   = (pwm_cnt == '1);
        active = enable & started_q;
    end

    // One table and one bridge stage per winding; winding 0 leads by a quarter.
    for (genvar w = 0; w < N_WIND; w++) begin : g_wind
        stp_wave_rom #(
            .IDX_W     (IDX_W),
            .MAG_W     (PWM_W),
            .PHASE_OFS ((w == 0) ? QTR : 0)
        ) u_rom (
            .idx (elec_angle),
            .mag (mag[w]),
            .neg (neg[w])
        );

        stp_bridge_pwm #(
            .CNT_W   (PWM_W),
            .GUARD_W (GUARD_W)
        ) u_bridge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwm_cnt   (pwm_cnt),
            .wrap      (wrap),
            .active    (active),
            .mag       (mag[w]),
            .mag_neg   (neg[w]),
            .guard_len (guard_len),
            .drv_fwd   (fwd[w]),
            .drv_rev   (rev[w])
        );
    end

    // Map the winding stages onto the gate outputs.
    always_comb begin
        a_fwd = fwd[0];
        a_rev = rev[0];
        b_fwd = fwd[1];
        b_rev = rev[1];
    end

endmodule

// File: rtl/stp_drv_chk.sv
// Property checker for the bridge driver, attached by bind.
// Relates the gate outputs to the inputs, the shared counter and the start
// flag of the top module.
module stp_drv_chk #(
    parameter int IDX_W = stp_pkg::ANG_W,
    parameter int PWM_W = stp_pkg::TBL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             step,
    input logic [IDX_W-1:0] elec_angle,
    input logic [PWM_W-1:0] pwm_cnt,
    input logic             started_q,
    input logic             a_fwd,
    input logic             a_rev,
    input logic             b_fwd,
    input logic             b_rev
);
    logic any_gate;
    assign any_gate = a_fwd | a_rev | b_fwd | b_rev;

    // R9: the diagonals of one bridge never conduct together.
    a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_fwd && a_rev) && !(b_fwd && b_rev));

    // R8: a low enable removes all drive.
    a_r8_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !any_gate);

    // R1: nothing conducts before the first period has completed.
    a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !any_gate);

    // R5: the last count of each period is always off.
    a_r5_low_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_cnt == '1) |-> !any_gate);

    // R2: the angle only moves after step was seen high.
    a_r2_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(elec_angle) |-> $past(step));

endmodule

bind stepper_microstep_drv stp_drv_chk #(.IDX_W(IDX_W), .PWM_W(PWM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .step       (step),
    .elec_angle (elec_angle),
    .pwm_cnt    (pwm_cnt),
    .started_q  (started_q),
    .a_fwd      (a_fwd),
    .a_rev      (a_rev),
    .b_fwd      (b_fwd),
    .b_rev      (b_rev)
);

// File: tb/stepper_microstep_drv_tb.sv
// Directed bench for the microstepping bridge driver.
module stepper_microstep_drv_tb;

    localparam real CYC = 10.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       step = 1'b0;
    logic       dir = 1'b1;
    logic [1:0] mode = 2'd3;
    logic [7:0] guard_len = 8'd0;
    logic [4:0] elec_angle;
    logic       a_fwd, a_rev, b_fwd, b_rev;

    int n_chk = 0;
    int n_bad = 0;
    int bc;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    // Bench model of the period counter required by R5.
    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    stepper_microstep_drv u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .step       (step),
        .dir        (dir),
        .mode       (mode),
        .guard_len  (guard_len),
        .elec_angle (elec_angle),
        .a_fwd      (a_fwd),
        .a_rev      (a_rev),
        .b_fwd      (b_fwd),
        .b_rev      (b_rev)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample one full counter period starting at count 0.
    task automatic measure(output int af, output int ar, output int bf,
                           output int br, output int ov, output int first);
        af = 0; ar = 0; bf = 0; br = 0; ov = 0; first = -1;
        while (bc[7:0] != 8'd0) @(negedge clk);
        for (int c = 0; c < 256; c++) begin
            if (c != 0) @(negedge clk);
            af += int'(a_fwd); ar += int'(a_rev);
            bf += int'(b_fwd); br += int'(b_rev);
            if ((a_fwd && a_rev) || (b_fwd && b_rev)) ov++;
            if (first < 0 && (a_fwd || a_rev)) first = c;
        end
    endtask

    // One step pulse, kept away from the wrap edge.
    task automatic pulse(input logic d, input logic [1:0] m);
        if (bc[7:0] == 8'd255) @(negedge clk);
        dir = d; mode = m; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        @(negedge clk);
    endtask

    function automatic int exp_mag(input int i, input bit use_cos);
        real th, v;
        th = 2.0 * 3.14159265358979 * i / 32.0;
        v  = use_cos ? $cos(th) : $sin(th);
        if (v < 0.0) v = -v;
        return $rtoi(255.0 * v + 0.5);
    endfunction

    task automatic t_reset();
        int hi = 0;
        int af, ar, bf, br, ov, fi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(elec_angle == 5'd0, "R1 angle after reset", elec_angle, 0);
        for (int c = 0; c < 256; c++) begin
            if (c != 0) @(negedge clk);
            if (a_fwd || a_rev || b_fwd || b_rev) hi++;
        end
        check(hi == 0, "R1 quiet first period", hi, 0);
        measure(af, ar, bf, br, ov, fi);
        check(af == 255 && ar + bf + br == 0, "R1 second period A fwd", af, 255);
    endtask

    task automatic t_table_sweep();
        int af, ar, bf, br, ov, fi;
        int ma, mb, ea, eb;
        guard_len = 8'd0;
        for (int i = 0; i < 32; i++) begin
            if (i > 0) pulse(1'b1, 2'd3);
            check(elec_angle == 5'(i), "R2 eighth step up", elec_angle, i);
            measure(af, ar, bf, br, ov, fi);
            ma = exp_mag(i, 1'b1);
            mb = exp_mag(i, 1'b0);
            ea = (i < 8 || i >= 24) ? ma * 1000 : ma;   // R4 polarity of A
            eb = (i < 16) ? mb * 1000 : mb;             // R4 polarity of B
            check(af * 1000 + ar == ea, $sformatf("R3 R4 R5 winding A at %0d", i), af * 1000 + ar, ea);
            check(bf * 1000 + br == eb, $sformatf("R3 R4 R5 winding B at %0d", i), bf * 1000 + br, eb);
        end
    endtask

    task automatic t_step_modes();
        pulse(1'b1, 2'd0);
        check(elec_angle == 5'd7, "R2 full up wrap", elec_angle, 7);
        pulse(1'b0, 2'd1);
        check(elec_angle == 5'd3, "R2 half down", elec_angle, 3);
        pulse(1'b0, 2'd2);
        check(elec_angle == 5'd1, "R2 quarter down", elec_angle, 1);
        pulse(1'b0, 2'd3);
        check(elec_angle == 5'd0, "R2 eighth down", elec_angle, 0);
        pulse(1'b0, 2'd3);
        check(elec_angle == 5'd31, "R2 down wrap", elec_angle, 31);
        pulse(1'b1, 2'd2);
        check(elec_angle == 5'd1, "R2 quarter up wrap", elec_angle, 1);
    endtask

    task automatic t_hold_step();
        dir = 1'b1; mode = 2'd3; step = 1'b1;
        repeat (6) @(negedge clk);
        dir = 1'b0;
        repeat (6) @(negedge clk);
        step = 1'b0;
        @(negedge clk);
        check(elec_angle == 5'd2, "R2 held step moves once", elec_angle, 2);
    endtask

    task automatic t_guard();
        int af, ar, bf, br, ov, fi;
        pulse(1'b1, 2'd2);                           // angle 4
        measure(af, ar, bf, br, ov, fi);
        check(af == 180 && bf == 180, "R3 angle 4 settle", af, 180);
        guard_len = 8'd10;
        pulse(1'b1, 2'd0);                           // angle 12, A flips
        measure(af, ar, bf, br, ov, fi);
        check(ar == 170 && af == 0, "R7 guard shortens A", ar, 170);
        check(fi == 10, "R7 first drive at guard end", fi, 10);
        check(bf == 180 && br == 0, "R7 unflipped B unaffected", bf, 180);
        check(ov == 0, "R9 no overlap", ov, 0);
    endtask

    task automatic t_enable();
        int af, ar, bf, br, ov, fi;
        enable = 1'b0;
        measure(af, ar, bf, br, ov, fi);
        check(af + ar + bf + br == 0, "R8 disabled gates low", af + ar + bf + br, 0);
        check(elec_angle == 5'd12, "R8 angle kept", elec_angle, 12);
        enable = 1'b1;
        measure(af, ar, bf, br, ov, fi);
        check(ar == 180 && bf == 180, "R8 drive resumes", ar, 180);
    endtask

    task automatic t_step_at_wrap();
        int af, ar, bf, br, ov, fi;
        while (bc[7:0] != 8'd255) @(negedge clk);
        dir = 1'b1; mode = 2'd1; step = 1'b1;        // sampled on the wrap edge
        @(negedge clk);
        step = 1'b0;
        check(elec_angle == 5'd16, "R6 angle moved on wrap", elec_angle, 16);
        measure(af, ar, bf, br, ov, fi);
        check(ar == 180 && bf == 180, "R6 old duty kept this period", ar, 180);
        measure(af, ar, bf, br, ov, fi);
        check(ar == 255 && bf + br == 0, "R6 new duty next period", ar, 255);
    endtask

    initial begin
        t_reset();
        t_table_sweep();
        t_step_modes();
        t_hold_step();
        t_guard();
        t_enable();
        t_step_at_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CYC * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule